// File: doc/BRIEF.md
# Rounded Product-High and Barrel-Shift Unit

This datapath slice produces a single 16-bit result register, the product-high register (PH). The register is fed by one of two operations. A five-bit operation code chooses between them, and a start strobe launches the operation. The operand is either the accumulator value or an offset copy of the accumulator, picked by a select bit.

The multiply operation forms the signed 32-bit product of the multiplier register and the operand. It rounds that product to nearest and keeps the upper half. The shift operation sign-extends the operand to 32 bits and moves it left by a 4-bit amount, filling with zeros from the right. It keeps the upper half of the result.

Both results land in the same PH register one clock after the strobe, and a valid flag marks that cycle. Instruction decode beyond the two codes and the accumulator writeback belong to neighbouring logic.

Top module: `prod_hi_unit`

## Requirements
- R1: While reset (rst_n low) is applied, and in the first cycle after it, ph_out is 0 and ph_valid is 0.
- R2: When start is high with opcode 5'b11110, ph_out on the next clock equals floor((MR × operand + 32768) / 65536), with both taken as 16-bit two's complement. This is bits 31:16 of the rounded product.
- R3: src_sel = 1 takes acc_in as the operand, and src_sel = 0 takes acc_ofs_in, for both operations.
- R4: When start is high with opcode 5'b11111, ph_out on the next clock equals bits 31:16 of the sign-extended operand shifted left by shamt_in (0 to 15), with zeros entering from the right.
- R5: ph_valid is high for exactly the one cycle after each accepted start, and is low at every other time.
- R6: While start is low, ph_out keeps its value. A start with any opcode other than the two above is ignored: ph_out holds and ph_valid stays low.
- R7: The rounding never wraps. Every multiply result lies within -16384 to 16384, so (-32768) × (-32768) gives 16'h4000. A guard clamps to 16'h7FFF if the rounding sum ever overflowed.
- R8: Starts on consecutive cycles each update ph_out on the following cycle, with ph_valid high throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe for one operation |
| opcode | input | 5 | 11110 = multiply, 11111 = shift left |
| src_sel | input | 1 | 1 = accumulator, 0 = offset accumulator |
| acc_in | input | 16 | Accumulator value |
| acc_ofs_in | input | 16 | Offset accumulator value |
| mr_in | input | 16 | Multiplier register value |
| shamt_in | input | 4 | Shift amount (low bits of the shift-value register) |
| ph_out | output | 16 | Product-high register |
| ph_valid | output | 1 | One-cycle flag for a new ph_out |

## Verification
The stimulus covers the following cases, with the failure each one would reveal:
- **Rounding boundary:** a product of exactly 32768 rounds up to 1, while 32767 rounds to 0. Truncating instead of rounding returns 0 for both.
- **Largest negative operands:** (-32768)² must give 16'h4000. An unsigned multiply or a wrong saturation threshold shows up here.
- **Shift extremes:** amounts 0 and 15 on negative operands expose a missing sign extension, because PH would show zeros instead of ones.
- **Illegal opcodes and idle cycles:** these catch a register that updates or flags when it should hold.
- **Back-to-back starts:** these catch a valid flag that drops between them.

// File: rtl/prod_pkg.sv
package prod_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned OPC_W   = 5;
  localparam int unsigned SHAMT_W = 4;
  localparam int unsigned PROD_W  = 2 * DATA_W;

  localparam logic [OPC_W-1:0] OPC_MUL = 5'b11110;
  localparam logic [OPC_W-1:0] OPC_SHL = 5'b11111;

  // Round-to-nearest upper half of a signed product, with an overflow clamp.
  function automatic logic [DATA_W-1:0] round_upper(input logic [PROD_W-1:0] prod);
    logic [PROD_W:0] sum;
    sum = {prod[PROD_W-1], prod}
        + {{(DATA_W+1){1'b0}}, 1'b1, {(DATA_W-1){1'b0}}};
    if (!sum[PROD_W] && sum[PROD_W-1])
      return {1'b0, {(DATA_W-1){1'b1}}};
    return sum[PROD_W-1:DATA_W];
  endfunction

  // Upper half of the sign-extended operand shifted left, zero fill.
  function automatic logic [DATA_W-1:0] shift_upper(input logic [DATA_W-1:0] opnd,
                                                    input logic [SHAMT_W-1:0] amt);
    logic [PROD_W-1:0] ext;
    ext = {{DATA_W{opnd[DATA_W-1]}}, opnd} << amt;
    return ext[PROD_W-1:DATA_W];
  endfunction
endpackage

// File: rtl/prod_opsel.sv
module prod_opsel
  import prod_pkg::*;
(
  input  logic              sel_acc,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] acc_ofs,
  output logic [DATA_W-1:0] operand
);
  always_comb operand = sel_acc ? acc : acc_ofs;
endmodule

// File: rtl/prod_mul_rnd.sv
module prod_mul_rnd
  import prod_pkg::*;
(
  input  logic [DATA_W-1:0] mr,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] hi
);
  logic signed [PROD_W-1:0] prod;
  always_comb begin
    prod = PROD_W'($signed(mr)) * PROD_W'($signed(opnd));
    hi   = round_upper(prod);
  end
endmodule

// File: rtl/prod_shl.sv
module prod_shl
  import prod_pkg::*;
(
  input  logic [DATA_W-1:0]  opnd,
  input  logic [SHAMT_W-1:0] amt,
  output logic [DATA_W-1:0]  hi
);
  always_comb hi = shift_upper(opnd, amt);
endmodule

// File: rtl/prod_hi_unit.sv
module prod_hi_unit
  import prod_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               src_sel,
  input  logic [DATA_W-1:0]  acc_in,
  input  logic [DATA_W-1:0]  acc_ofs_in,
  input  logic [DATA_W-1:0]  mr_in,
  input  logic [SHAMT_W-1:0] shamt_in,
  output logic [DATA_W-1:0]  ph_out,
  output logic               ph_valid
);
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] mul_hi;
  logic [DATA_W-1:0] shl_hi;
  logic [DATA_W-1:0] ph_next;
  logic              mul_fire;
  logic              shl_fire;
  logic              op_fire;

  prod_opsel u_sel (
    .sel_acc (src_sel),
    .acc     (acc_in),
    .acc_ofs (acc_ofs_in),
    .operand (operand)
  );

  prod_mul_rnd u_mul (
    .mr   (mr_in),
    .opnd (operand),
    .hi   (mul_hi)
  );

  prod_shl u_shl (
    .opnd (operand),
    .amt  (shamt_in),
    .hi   (shl_hi)
  );

  always_comb begin
    mul_fire = start && (opcode == OPC_MUL);
    shl_fire = start && (opcode == OPC_SHL);
    op_fire  = mul_fire || shl_fire;
    ph_next  = mul_fire ? mul_hi : shl_hi;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_out   <= '0;
      ph_valid <= 1'b0;
    end else begin
      ph_valid <= op_fire;
      if (op_fire) ph_out <= ph_next;
    end
  end
endmodule

// File: rtl/prod_hi_unit_chk.sv
module prod_hi_unit_chk
  import prod_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mul_fire,
  input logic               shl_fire,
  input logic               op_fire,
  input logic [DATA_W-1:0]  operand,
  input logic [DATA_W-1:0]  mul_hi,
  input logic [SHAMT_W-1:0] shamt_in,
  input logic [DATA_W-1:0]  ph_out,
  input logic               ph_valid
);
  // R5
  fire_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_fire |=> ph_valid);

  // R5
  valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid |-> $past(op_fire));

  // R6
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_valid |-> $stable(ph_out));

  // R2
  mul_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |=> (ph_out == $past(mul_hi)));

  // R4
  shift_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shl_fire && shamt_in == '0) |=> (ph_out == {DATA_W{$past(operand[DATA_W-1])}}));

  // R7
  mul_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_fire |=> ($signed(ph_out) <= 16384 && $signed(ph_out) >= -16384));

  // R5
  fire_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mul_fire, shl_fire}));
endmodule

bind prod_hi_unit prod_hi_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mul_fire (mul_fire),
  .shl_fire (shl_fire),
  .op_fire  (op_fire),
  .operand  (operand),
  .mul_hi   (mul_hi),
  .shamt_in (shamt_in),
  .ph_out   (ph_out),
  .ph_valid (ph_valid)
);

// File: tb/prod_hi_unit_test.sv
`timescale 1ns/1ps
module prod_hi_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  opcode = '0;
  logic        src_sel = 1'b0;
  logic [15:0] acc_in = '0;
  logic [15:0] acc_ofs_in = '0;
  logic [15:0] mr_in = '0;
  logic [3:0]  shamt_in = '0;
  logic [15:0] ph_out;
  logic        ph_valid;

  int errors = 0;
  int checks = 0;
  logic [15:0] model_ph = '0;
  logic        model_v  = 1'b0;
  logic [16:0] exp_q[$];

  always #2.5 clk = ~clk;

  prod_hi_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .src_sel(src_sel),
    .acc_in(acc_in), .acc_ofs_in(acc_ofs_in), .mr_in(mr_in), .shamt_in(shamt_in),
    .ph_out(ph_out), .ph_valid(ph_valid)
  );

  function automatic logic [15:0] ref_mul(input logic [15:0] a, input logic [15:0] b);
    longint p;
    longint r;
    p = longint'($signed(a)) * longint'($signed(b)) + 32768;
    r = p >>> 16;
    if (r > 32767) r = 32767;
    return 16'(r);
  endfunction

  function automatic logic [15:0] ref_shl(input logic [15:0] a, input int n);
    longint v;
    v = longint'($signed(a)) * (longint'(1) << n);
    return 16'(v >>> 16);
  endfunction

  task automatic check(input string req, input logic [15:0] exp_ph, input logic exp_v);
    checks++;
    if (ph_out !== exp_ph || ph_valid !== exp_v) begin
      errors++;
      $display("FAIL %s: ph_out=%h ph_valid=%b expected ph_out=%h ph_valid=%b",
               req, ph_out, ph_valid, exp_ph, exp_v);
    end
  endtask

  // One clock: drive at negedge, predict, compare just after the posedge.
  task automatic step(input string req, input logic st, input logic [4:0] op,
                      input logic sel, input logic [15:0] a, input logic [15:0] o,
                      input logic [15:0] m, input logic [3:0] n);
    logic [15:0] opnd;
    logic [16:0] e;
    @(negedge clk);
    start = st; opcode = op; src_sel = sel; acc_in = a; acc_ofs_in = o;
    mr_in = m; shamt_in = n;
    opnd = sel ? a : o;
    if (st && op == 5'd30) begin model_ph = ref_mul(m, opnd); model_v = 1'b1; end
    else if (st && op == 5'd31) begin model_ph = ref_shl(opnd, int'(n)); model_v = 1'b1; end
    else model_v = 1'b0;
    exp_q.push_back({model_v, model_ph});
    @(posedge clk);
    #1;
    e = exp_q.pop_front();
    check(req, e[15:0], e[16]);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: ph_out=%h ph_valid=%b expected run to complete", ph_out, ph_valid);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 16'h0000, 1'b0);
    rst_n = 1'b1;
    step("R1 after reset", 0, 5'd0, 0, 16'h1234, 16'h5678, 16'h7FFF, 4'd3);

    // multiply, several patterns
    step("R2 basic", 1, 5'd30, 1, 16'd1000, 16'd0, 16'd3000, 4'd0);
    step("R2 round up at 32768", 1, 5'd30, 1, 16'd128, 16'd0, 16'd256, 4'd0);
    step("R2 no round at 32767", 1, 5'd30, 1, 16'd32767, 16'd0, 16'd1, 4'd0);
    step("R2 negative", 1, 5'd30, 1, 16'hFF00, 16'd0, 16'd300, 4'd0);
    step("R2 -32768*1", 1, 5'd30, 1, 16'h8000, 16'd0, 16'd1, 4'd0);
    step("R7 max negative squared", 1, 5'd30, 0, 16'd0, 16'h8000, 16'h8000, 4'd0);
    step("R7 max positive squared", 1, 5'd30, 0, 16'd0, 16'h7FFF, 16'h7FFF, 4'd0);
    step("R7 mixed extremes", 1, 5'd30, 1, 16'h8000, 16'd0, 16'h7FFF, 4'd0);

    // operand selection
    step("R3 select acc", 1, 5'd30, 1, 16'd20000, 16'd5, 16'd20000, 4'd0);
    step("R3 select offset", 1, 5'd30, 0, 16'd20000, 16'd5, 16'd20000, 4'd0);
    step("R3 shift offset", 1, 5'd31, 0, 16'h0001, 16'h4000, 16'd0, 4'd4);

    // shift
    step("R4 shift 0 negative", 1, 5'd31, 1, 16'h8001, 16'd0, 16'd0, 4'd0);
    step("R4 shift 0 positive", 1, 5'd31, 1, 16'h7001, 16'd0, 16'd0, 4'd0);
    step("R4 shift 15 negative", 1, 5'd31, 1, 16'hFFFF, 16'd0, 16'd0, 4'd15);
    step("R4 shift 15 pattern", 1, 5'd31, 1, 16'h0003, 16'd0, 16'd0, 4'd15);
    step("R4 shift 8", 1, 5'd31, 1, 16'hABCD, 16'd0, 16'd0, 4'd8);

    // ignored and idle
    step("R6 idle hold", 0, 5'd30, 1, 16'h1111, 16'd0, 16'h2222, 4'd0);
    step("R6 illegal opcode", 1, 5'd29, 1, 16'h1111, 16'd0, 16'h2222, 4'd0);
    step("R6 opcode zero", 1, 5'd0, 1, 16'h1111, 16'd0, 16'h2222, 4'd0);
    step("R5 valid low again", 0, 5'd31, 1, 16'h1111, 16'd0, 16'h2222, 4'd1);

    // back-to-back
    step("R8 burst 1", 1, 5'd30, 1, 16'd7, 16'd0, 16'd9000, 4'd0);
    step("R8 burst 2", 1, 5'd31, 1, 16'h1234, 16'd0, 16'd0, 4'd12);
    step("R8 burst 3", 1, 5'd30, 0, 16'd0, 16'hC000, 16'h4000, 4'd0);
    step("R5 after burst", 0, 5'd0, 0, 16'd0, 16'd0, 16'd0, 4'd0);

    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      op = ($urandom % 4 == 0) ? 5'($urandom) : (($urandom % 2 == 0) ? 5'd30 : 5'd31);
      step(op == 5'd30 ? "R2 random" : (op == 5'd31 ? "R4 random" : "R6 random"),
           ($urandom % 3 != 0), op, 1'($urandom), 16'($urandom), 16'($urandom),
           16'($urandom), 4'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule